// File: doc/BRIEF.md
# Serial Peripheral Slave with Self-Framing Byte Exchange

This block is the device side of a four-wire serial peripheral link. It runs on a fast system clock and oversamples the serial clock, the master-out data line and the active-low select. Each frame exchanges one byte in both directions at once: the master's shift register and this block's shift register form one ring. The timing is fixed at phase mode 1, where a bit is launched on the edge that leaves the idle level and captured on the return edge. Clock idle level and bit order are set by two static configuration pins.

Frames are recognised in two ways. With a driven select, a frame is any run of eight bits while select is low, and raising select early throws away a partial byte. With select tied low, the first launching edge after a finished byte opens the next frame. Bit counting alone marks where each frame ends. When select is high, the output-enable for the slave-out line is low so the line can float, and clock activity is ignored.

On the parallel side, the received byte comes out with a single-cycle valid strobe. This path has no ready signal, because the serial master cannot be stalled. The next byte to send enters through a valid/ready pair feeding a one-entry holding register. The ready signal is high only while that register is empty. The register is emptied when a frame begins. A frame that begins with nothing loaded sends the previous byte again and raises an underrun flag.

Top module: `spi_slave_frame`

## Requirements
- R1: While select (`spi_ssel_n`) is high, `spi_miso_oe` is 0 and serial clock edges have no effect: no `rx_valid` pulse occurs and the bit position of the next selected frame starts from zero.
- R2: While select is low, `spi_miso_oe` is 1.
- R3: With `cfg_cpol` as the idle level, the edge leaving the idle level launches the next `spi_miso` bit, and the edge returning to idle captures `spi_mosi`. The first launching edge of a frame already presents the first bit.
- R4: `cfg_cpol`=0 selects a low idle clock and `cfg_cpol`=1 a high idle clock. The launch and capture roles of the edges follow that idle level.
- R5: `cfg_lsb_first`=1 sends and receives bit 0 first; `cfg_lsb_first`=0 sends and receives bit 7 first. The same order applies to both lines.
- R6: After the eighth capture of a frame, `rx_data` holds the assembled byte and `rx_valid` is 1 for exactly one clock. There is no back-pressure on this path.
- R7: With select held low across several frames, each launching edge that follows a completed byte starts a new frame, and consecutive bytes are exchanged correctly.
- R8: `tx_ready` is 1 exactly when the holding register is empty. A byte is taken on a cycle with `tx_valid` and `tx_ready` both 1. The held byte is moved into the shifter at the next frame start, and `tx_ready` then returns to 1. While `tx_ready` is 0, a byte on `tx_data` is not accepted.
- R9: If a frame starts with the holding register empty, the previously sent byte (0 after reset) is sent again and `tx_underrun` goes to 1. The flag returns to 0 when the next byte is accepted.
- R10: A rise of select before the eighth capture discards the partial byte: no `rx_valid` pulse occurs, and the following frame is received from bit zero.
- R11: After reset, `spi_miso_oe`=0, `rx_valid`=0, `tx_ready`=1 and `tx_underrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_lsb_first | input | 1 | 1: bit 0 first, 0: bit 7 first |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_ssel_n | input | 1 | Active-low select, may be tied low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (1 = drive) |
| tx_data | input | DATA_W | Next byte to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Holding register empty, byte will be taken |
| tx_underrun | output | 1 | A frame started with nothing loaded |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |

## Verification
The assertions assume three things about the inputs. The select line stays at one level for several system clocks at a time. Serial clock half-periods span well over the synchroniser depth, so the output-enable and receive strobe are settled once a select level has persisted. `tx_valid` is the only cause of a fall in `tx_ready`. The stimulus drives every input on the falling system clock edge. It uses serial half-periods of eight system clocks, changes configuration pins only while select is high with the clock parked at its new idle level, and keeps select steady for several cycles around each frame.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

  // One system-clock view of the synchronised serial pins.
  typedef struct packed {
    logic sel;    // select asserted (active high after inversion)
    logic mosi;   // synchronised master-out data
    logic lead;   // clock left its idle level this cycle
    logic trail;  // clock returned to its idle level this cycle
  } spi_evt_t;

  localparam int unsigned SPI_SYNC_MIN = 2;

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync
  import spi_slv_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cpol,
  input  logic     sclk_raw,
  input  logic     ssel_n_raw,
  input  logic     mosi_raw,
  output spi_evt_t evt
);

  localparam int unsigned NST = (STAGES < SPI_SYNC_MIN) ? SPI_SYNC_MIN : STAGES;

  logic [NST-1:0] sck_q;
  logic [NST-1:0] ssn_q;
  logic [NST-1:0] mo_q;
  logic           norm_prev;
  logic           norm_now;

  // Capture stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q[0] <= 1'b0;
      ssn_q[0] <= 1'b1;
      mo_q[0]  <= 1'b0;
    end else begin
      sck_q[0] <= sclk_raw;
      ssn_q[0] <= ssel_n_raw;
      mo_q[0]  <= mosi_raw;
    end
  end

  // Remaining metastability stages.
  for (genvar g = 1; g < NST; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sck_q[g] <= 1'b0;
        ssn_q[g] <= 1'b1;
        mo_q[g]  <= 1'b0;
      end else begin
        sck_q[g] <= sck_q[g-1];
        ssn_q[g] <= ssn_q[g-1];
        mo_q[g]  <= mo_q[g-1];
      end
    end
  end

  // Clock normalised so that 0 is the idle level.
  assign norm_now = sck_q[NST-1] ^ cpol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) norm_prev <= 1'b0;
    else        norm_prev <= norm_now;
  end

  always_comb begin
    evt.sel   = ~ssn_q[NST-1];
    evt.mosi  = mo_q[NST-1];
    evt.lead  = norm_now & ~norm_prev;
    evt.trail = ~norm_now & norm_prev;
  end

endmodule

// File: rtl/spi_tx_hold.sv
module spi_tx_hold #(
  parameter int unsigned         W    = 8,
  parameter logic [W-1:0]        FILL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tx_data,
  input  logic         tx_valid,
  output logic         tx_ready,
  input  logic         take,
  output logic [W-1:0] frame_byte,
  output logic         underrun
);

  logic         full_q;
  logic [W-1:0] hold_q;
  logic [W-1:0] last_q;
  logic         accept;

  assign tx_ready   = ~full_q;
  assign accept     = tx_valid & ~full_q;
  assign frame_byte = full_q ? hold_q : last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q   <= 1'b0;
      hold_q   <= FILL;
      last_q   <= FILL;
      underrun <= 1'b0;
    end else begin
      if (accept) hold_q <= tx_data;
      full_q <= accept | (full_q & ~take);
      if (take && full_q) last_q <= hold_q;
      // A frame start on an empty register wins over a same-cycle load.
      if (take && !full_q) underrun <= 1'b1;
      else if (accept)     underrun <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
  import spi_slv_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lsb_first,
  input  spi_evt_t     evt,
  input  logic [W-1:0] frame_byte,
  output logic         take,
  output logic         miso,
  output logic [W-1:0] rx_data,
  output logic         rx_valid
);

  localparam int unsigned   CW    = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LASTC = CW'(W - 1);

  logic          in_frame;
  logic [CW-1:0] cnt;
  logic [W-1:0]  cur;
  logic [W-1:0]  rx_sr;
  logic [W-1:0]  rx_next;

  // Bit lane used at a given step of the frame.
  function automatic logic [CW-1:0] lane(input logic [CW-1:0] step, input logic lsb);
    lane = lsb ? step : (LASTC - step);
  endfunction

  assign take    = evt.sel & evt.lead & ~in_frame;
  assign rx_next = lsb_first ? {evt.mosi, rx_sr[W-1:1]} : {rx_sr[W-2:0], evt.mosi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      cnt      <= '0;
      cur      <= '0;
      rx_sr    <= '0;
      miso     <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!evt.sel) begin
        in_frame <= 1'b0;
        cnt      <= '0;
      end else begin
        if (evt.lead) begin
          if (!in_frame) begin
            cur      <= frame_byte;
            miso     <= frame_byte[lane('0, lsb_first)];
            in_frame <= 1'b1;
          end else begin
            miso <= cur[lane(cnt, lsb_first)];
          end
        end
        if (evt.trail && in_frame) begin
          rx_sr <= rx_next;
          if (cnt == LASTC) begin
            cnt      <= '0;
            in_frame <= 1'b0;
            rx_data  <= rx_next;
            rx_valid <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_slave_frame.sv
module spi_slave_frame
  import spi_slv_pkg::*;
#(
  parameter int unsigned       DATA_W      = 8,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] TX_FILL     = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_lsb_first,
  input  logic              spi_sclk,
  input  logic              spi_ssel_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_underrun,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);

  spi_evt_t          evt;
  logic              take;
  logic [DATA_W-1:0] frame_byte;

  spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpol       (cfg_cpol),
    .sclk_raw   (spi_sclk),
    .ssel_n_raw (spi_ssel_n),
    .mosi_raw   (spi_mosi),
    .evt        (evt)
  );

  spi_tx_hold #(.W(DATA_W), .FILL(TX_FILL)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .take       (take),
    .frame_byte (frame_byte),
    .underrun   (tx_underrun)
  );

  spi_bit_engine #(.W(DATA_W)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .lsb_first  (cfg_lsb_first),
    .evt        (evt),
    .frame_byte (frame_byte),
    .take       (take),
    .miso       (spi_miso),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid)
  );

  assign spi_miso_oe = evt.sel;

endmodule

// File: rtl/spi_slave_frame_chk.sv
module spi_slave_frame_chk #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic spi_ssel_n,
  input logic spi_miso_oe,
  input logic rx_valid,
  input logic tx_valid,
  input logic tx_ready,
  input logic tx_underrun
);

  localparam int unsigned HL = SYNC_STAGES + 1;

  logic [HL-1:0] ssn_hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ssn_hist <= '1;
    else        ssn_hist <= {ssn_hist[HL-2:0], spi_ssel_n};
  end

  AST_QUIET_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    (&ssn_hist) |-> (!spi_miso_oe && !rx_valid)); // R1
  AST_DRIVE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (~|ssn_hist) |-> spi_miso_oe); // R2
  AST_RX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R6
  AST_READY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready) |-> $past(tx_valid)); // R8
  AST_UNDERRUN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_underrun) |-> $past(tx_ready)); // R9

endmodule

bind spi_slave_frame spi_slave_frame_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .spi_ssel_n  (spi_ssel_n),
  .spi_miso_oe (spi_miso_oe),
  .rx_valid    (rx_valid),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .tx_underrun (tx_underrun)
);

// File: tb/tb_spi_slave_frame.sv
module tb_spi_slave_frame;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_cpol = 1'b0;
  logic       cfg_lsb_first = 1'b0;
  logic       spi_sclk = 1'b0;
  logic       spi_ssel_n = 1'b1;
  logic       spi_mosi = 1'b0;
  logic       spi_miso;
  logic       spi_miso_oe;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic       tx_underrun;
  logic [7:0] rx_data;
  logic       rx_valid;

  int   checks = 0;
  int   errors = 0;
  int   nrx = 0;
  logic [7:0] rx_last = 8'h00;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  spi_slave_frame dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_lsb_first(cfg_lsb_first),
    .spi_sclk(spi_sclk), .spi_ssel_n(spi_ssel_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_underrun(tx_underrun),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_last <= rx_data;
      nrx     <= nrx + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] d);
    @(negedge clk);
    tx_data  = d;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // Master side: launches on the edge leaving idle, samples just before the return edge.
  task automatic xfer(input logic [7:0] mo, input int nbits, output logic [7:0] mi, output bit oe_ok);
    mi = 8'h00;
    oe_ok = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      int idx;
      idx = cfg_lsb_first ? i : 7 - i;
      @(negedge clk);
      spi_sclk = ~cfg_cpol;
      spi_mosi = mo[idx];
      idle(HALF);
      mi[idx] = spi_miso;
      if (!spi_miso_oe) oe_ok = 1'b0;
      spi_sclk = cfg_cpol;
      idle(HALF);
    end
    idle(4);
  endtask

  task automatic set_mode(input logic cpol, input logic lsb);
    @(negedge clk);
    spi_ssel_n    = 1'b1;
    cfg_cpol      = cpol;
    cfg_lsb_first = lsb;
    spi_sclk      = cpol;
    idle(8);
  endtask

  task automatic t_reset;
    chk(spi_miso_oe == 1'b0, "R11 oe", spi_miso_oe, 0);
    chk(rx_valid == 1'b0, "R11 rx_valid", rx_valid, 0);
    chk(tx_ready == 1'b1, "R11 tx_ready", tx_ready, 1);
    chk(tx_underrun == 1'b0, "R11 underrun", tx_underrun, 0);
  endtask

  task automatic t_basic_msb;
    logic [7:0] mi; bit ok; int n0;
    set_mode(1'b0, 1'b0);
    load(8'hA5);
    chk(tx_ready == 1'b0, "R8 ready low when held", tx_ready, 0);
    n0 = nrx;
    spi_ssel_n = 1'b0; idle(6);
    xfer(8'h3C, 8, mi, ok);
    chk(ok, "R2 oe while selected", ok, 1);
    chk(mi == 8'hA5, "R3 R4 R5 miso msb-first cpol0", mi, 8'hA5);
    chk(nrx == n0 + 1, "R6 one strobe", nrx - n0, 1);
    chk(rx_last == 8'h3C, "R6 R5 rx msb-first", rx_last, 8'h3C);
    chk(tx_ready == 1'b1 && tx_underrun == 1'b0, "R8 ready after take", tx_ready, 1);
    spi_ssel_n = 1'b1; idle(6);
    chk(spi_miso_oe == 1'b0, "R1 oe off after deselect", spi_miso_oe, 0);
  endtask

  task automatic t_lsb_cpol1;
    logic [7:0] mi; bit ok;
    set_mode(1'b1, 1'b1);
    load(8'h1E);
    spi_ssel_n = 1'b0; idle(6);
    xfer(8'hC4, 8, mi, ok);
    chk(mi == 8'h1E, "R4 R5 miso lsb-first cpol1", mi, 8'h1E);
    chk(rx_last == 8'hC4, "R4 R5 rx lsb-first cpol1", rx_last, 8'hC4);
    spi_ssel_n = 1'b1; idle(6);
  endtask

  task automatic t_tied_low;
    logic [7:0] mi; bit ok; int n0;
    set_mode(1'b0, 1'b0);
    load(8'h5A);
    n0 = nrx;
    spi_ssel_n = 1'b0; idle(6);
    xfer(8'h96, 8, mi, ok);
    chk(mi == 8'h5A && rx_last == 8'h96, "R7 tied-low frame 1", {mi, rx_last}, 16'h5A96);
    load(8'h0F);
    xfer(8'hF0, 8, mi, ok);
    chk(mi == 8'h0F && rx_last == 8'hF0, "R7 tied-low frame 2", {mi, rx_last}, 16'h0FF0);
    chk(nrx == n0 + 2, "R7 two strobes", nrx - n0, 2);
    chk(tx_underrun == 1'b0, "R9 no underrun when loaded", tx_underrun, 0);
  endtask

  task automatic t_underrun;
    logic [7:0] mi; bit ok;
    xfer(8'h69, 8, mi, ok);
    chk(mi == 8'h0F, "R9 resend previous byte", mi, 8'h0F);
    chk(tx_underrun == 1'b1, "R9 underrun set", tx_underrun, 1);
    chk(rx_last == 8'h69, "R9 rx still works", rx_last, 8'h69);
    load(8'h33);
    chk(tx_underrun == 1'b0, "R9 underrun cleared by load", tx_underrun, 0);
    xfer(8'h00, 8, mi, ok);
    chk(mi == 8'h33, "R9 new byte after clear", mi, 8'h33);
    spi_ssel_n = 1'b1; idle(6);
  endtask

  task automatic t_abort;
    logic [7:0] mi; bit ok; int n0;
    load(8'h77);
    n0 = nrx;
    spi_ssel_n = 1'b0; idle(6);
    xfer(8'hFF, 3, mi, ok);
    spi_ssel_n = 1'b1; idle(8);
    chk(nrx == n0, "R10 no strobe for partial", nrx - n0, 0);
    load(8'hE1);
    spi_ssel_n = 1'b0; idle(6);
    xfer(8'h2B, 8, mi, ok);
    chk(rx_last == 8'h2B, "R10 next frame from bit zero", rx_last, 8'h2B);
    chk(mi == 8'hE1, "R10 next frame miso", mi, 8'hE1);
    spi_ssel_n = 1'b1; idle(6);
  endtask

  task automatic t_deselected_clock;
    logic [7:0] mi; bit ok; int n0;
    n0 = nrx;
    xfer(8'hA3, 5, mi, ok);
    chk(nrx == n0, "R1 no strobe deselected", nrx - n0, 0);
    chk(spi_miso_oe == 1'b0, "R1 oe stays off", spi_miso_oe, 0);
    spi_ssel_n = 1'b0; idle(6);
    xfer(8'hD2, 8, mi, ok);
    chk(rx_last == 8'hD2, "R1 count untouched by ignored edges", rx_last, 8'hD2);
    chk(mi == 8'hE1, "R9 resend after ignored edges", mi, 8'hE1);
    spi_ssel_n = 1'b1; idle(6);
  endtask

  task automatic t_backpressure;
    logic [7:0] mi; bit ok;
    load(8'h11);
    @(negedge clk);
    tx_data  = 8'h22;
    tx_valid = 1'b1;
    idle(5);
    chk(tx_ready == 1'b0, "R8 ready stays low when full", tx_ready, 0);
    tx_valid = 1'b0;
    spi_ssel_n = 1'b0; idle(6);
    xfer(8'h4D, 8, mi, ok);
    chk(mi == 8'h11, "R8 refused byte not sent", mi, 8'h11);
    chk(tx_ready == 1'b1, "R8 ready back after frame", tx_ready, 1);
    spi_ssel_n = 1'b1; idle(6);
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_basic_msb();
    t_lsb_cpol1();
    t_tied_low();
    t_underrun();
    t_abort();
    t_deselected_clock();
    t_backpressure();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule